// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for a parallel RGB LCD panel. Software programs the line and frame totals, the end of the active area, the horizontal and vertical sync windows and an internal horizontal retrace window through a 32-bit register port. Each window is one word, with the vertical value in the upper half and the horizontal value in the lower half. A programmable divider turns the system clock into a dot-rate enable. Two counters step through the raster at that rate. Comparators against the programmed positions produce horizontal sync, vertical sync and data-enable with selectable polarity. The counters are also brought out as the current pixel coordinates.

A small interrupt unit records frame completion, pixel underrun and bus error events in sticky status bits. Software clears each of these by writing one to it. A soft engine reset bit and a display-output enable bit park the raster at the origin and force every timing output to its idle level. Pixel fetch and colour handling are outside this block. Underrun and bus errors therefore arrive as one-cycle event inputs from the fetch logic.

Top module: `lcd_crtc_gen`

## Requirements
- R1: The horizontal counter `pix_x` advances by one on each dot tick and returns to 0 after reaching horizontal total minus one (TOTAL register bits [15:0]). At that return, the vertical counter `pix_y` advances. `pix_y` returns to 0 after reaching vertical total minus one (TOTAL bits [31:16]).
- R2: Data-enable is active while `pix_x` < DEND bits [15:0] and `pix_y` < DEND bits [31:16]. DEVCTL bit 28 sets its polarity: 0 means active high, 1 means active low.
- R3: Horizontal sync is active while HSYNC bits [13:0] <= `pix_x` < HSYNC bits [29:16]. DEVCTL bit 20 sets its polarity: 1 means active high, 0 means active low. HSYNC bits [31:30] are stored and read back but have no effect on timing.
- R4: Vertical sync is active while VSYNC bits [15:0] <= `pix_y` < VSYNC bits [31:16]. DEVCTL bit 21 sets its polarity: 1 means active high.
- R5: `retrace_o` is high while RETRACE bits [15:0] <= `pix_x` < RETRACE bits [31:16]. It is independent of horizontal sync.
- R6: With divider value D in the DIV register, the counters advance once every D+1 clocks. The first advance comes D+1 clocks after the raster starts running.
- R7: While CTRL bit 0 (engine reset) is 1 or CTRL bit 3 (display output enable) is 0, the counters are held at 0. In that state data-enable, horizontal sync and vertical sync sit at their inactive levels and `retrace_o` is 0.
- R8: On the dot tick that wraps both counters, IRQ bit 30 (frame status) sets. IRQ bit 31 (frame interrupt) sets on the same tick only if IRQ bit 0 (frame enable) is 1.
- R9: A pulse on `underrun_evt` sets IRQ bit 29. A pulse on `bus_err_evt` sets IRQ bit 28.
- R10: Writing the IRQ register with a 1 in bit 28, 29, 30 or 31 clears that status bit. A 0 in that bit leaves it unchanged. If a new event arrives in the same cycle as the clear, the event wins. IRQ bits [1:0] are plain read/write enables.
- R11: `irq_o` = CTRL bit 4 AND (IRQ bit 31 OR (IRQ bit 29 AND IRQ bit 1)). Bus error does not raise `irq_o`.
- R12: The registers sit at these byte offsets: CTRL 0x00, DEVCTL 0x04, IRQ 0x08, TOTAL 0x0C, DEND 0x10, RETRACE 0x14, HSYNC 0x18, VSYNC 0x1C, DIV 0x20. A read returns the stored bits. Unimplemented bits read as 0; the HSYNC read mask is 0xFFFF3FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (6) | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| underrun_evt | input | 1 | One-cycle pixel underrun event |
| bus_err_evt | input | 1 | One-cycle bus error event |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| retrace_o | output | 1 | Internal horizontal retrace window |
| pix_tick_o | output | 1 | Dot-rate enable |
| pix_x | output | 16 | Current horizontal position |
| pix_y | output | 16 | Current vertical position |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the window edges of every comparator: the last active pixel, the first blanked pixel, and the sync start and end pixels. A design with an inclusive end compare, or an off-by-one wrap, shows a wrong level or coordinate at exactly those points. The frame-wrap cycle is checked so that a status bit set one tick early or late is caught. The frame interrupt is also run with its enable cleared, which exposes a design that ignores the enable. Write-zero and write-one to the sticky bits separate a real write-one-to-clear from a plain register. Reset, disable and divider sequences catch outputs left active while parked, and a dot tick that comes one clock early.

// File: rtl/lcd_crtc_gen.sv
`timescale 1ns/1ps
module lcd_crtc_gen #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          underrun_evt,
  input  logic          bus_err_evt,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          retrace_o,
  output logic          pix_tick_o,
  output logic [15:0]   pix_x,
  output logic [15:0]   pix_y,
  output logic          irq_o
);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h00);
  localparam logic [AW-1:0] A_DEV  = AW'(8'h04);
  localparam logic [AW-1:0] A_IRQ  = AW'(8'h08);
  localparam logic [AW-1:0] A_TOT  = AW'(8'h0C);
  localparam logic [AW-1:0] A_DEND = AW'(8'h10);
  localparam logic [AW-1:0] A_RTR  = AW'(8'h14);
  localparam logic [AW-1:0] A_HS   = AW'(8'h18);
  localparam logic [AW-1:0] A_VS   = AW'(8'h1C);
  localparam logic [AW-1:0] A_DIV  = AW'(8'h20);
  localparam logic [31:0]   HS_MASK = 32'hFFFF_3FFF;

  logic eng_rst_q, out_en_q, dirq_en_q;
  logic hpol_q, vpol_q, depol_q;
  logic [31:0] tot_q, dend_q, rtr_q, hs_q, vs_q;
  logic [DW-1:0] div_q, div_cnt;
  logic [1:0] ien_q;
  logic st_fi, st_fd, st_ur, st_be;
  logic [15:0] hcnt, vcnt;

  wire running = out_en_q & ~eng_rst_q;
  wire tick    = running & (div_cnt >= div_q);
  wire h_last  = hcnt >= (tot_q[15:0] - 16'd1);
  wire v_last  = vcnt >= (tot_q[31:16] - 16'd1);
  wire fwrap   = tick & h_last & v_last;
  wire irq_wr  = reg_we && (reg_addr == A_IRQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eng_rst_q <= 1'b0; out_en_q <= 1'b0; dirq_en_q <= 1'b0;
      hpol_q <= 1'b0; vpol_q <= 1'b0; depol_q <= 1'b0;
      tot_q <= '0; dend_q <= '0; rtr_q <= '0; hs_q <= '0; vs_q <= '0;
      div_q <= '0; ien_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL: begin
          eng_rst_q <= reg_wdata[0];
          out_en_q  <= reg_wdata[3];
          dirq_en_q <= reg_wdata[4];
        end
        A_DEV: begin
          hpol_q  <= reg_wdata[20];
          vpol_q  <= reg_wdata[21];
          depol_q <= reg_wdata[28];
        end
        A_IRQ:  ien_q  <= reg_wdata[1:0];
        A_TOT:  tot_q  <= reg_wdata;
        A_DEND: dend_q <= reg_wdata;
        A_RTR:  rtr_q  <= reg_wdata;
        A_HS:   hs_q   <= reg_wdata & HS_MASK;
        A_VS:   vs_q   <= reg_wdata;
        A_DIV:  div_q  <= reg_wdata[DW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !running) begin
      hcnt <= '0; vcnt <= '0; div_cnt <= '0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) begin
        if (h_last) begin
          hcnt <= '0;
          vcnt <= v_last ? '0 : vcnt + 16'd1;
        end else begin
          hcnt <= hcnt + 16'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_fi <= 1'b0; st_fd <= 1'b0; st_ur <= 1'b0; st_be <= 1'b0;
    end else begin
      st_fi <= (fwrap & ien_q[0]) | (st_fi & ~(irq_wr & reg_wdata[31]));
      st_fd <= fwrap              | (st_fd & ~(irq_wr & reg_wdata[30]));
      st_ur <= underrun_evt       | (st_ur & ~(irq_wr & reg_wdata[29]));
      st_be <= bus_err_evt        | (st_be & ~(irq_wr & reg_wdata[28]));
    end
  end

  wire de_raw  = (hcnt < dend_q[15:0]) && (vcnt < dend_q[31:16]);
  wire hs_raw  = (hcnt >= {2'b00, hs_q[13:0]}) && (hcnt < {2'b00, hs_q[29:16]});
  wire vs_raw  = (vcnt >= vs_q[15:0]) && (vcnt < vs_q[31:16]);
  wire rtr_raw = (hcnt >= rtr_q[15:0]) && (hcnt < rtr_q[31:16]);

  assign hsync_o    = ~((running & hs_raw) ^ hpol_q);
  assign vsync_o    = ~((running & vs_raw) ^ vpol_q);
  assign de_o       = (running & de_raw) ^ depol_q;
  assign retrace_o  = running & rtr_raw;
  assign pix_tick_o = tick;
  assign pix_x      = hcnt;
  assign pix_y      = vcnt;
  assign irq_o      = dirq_en_q & (st_fi | (st_ur & ien_q[1]));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata = {27'd0, dirq_en_q, out_en_q, 2'b00, eng_rst_q};
      A_DEV:  reg_rdata = {3'd0, depol_q, 6'd0, vpol_q, hpol_q, 20'd0};
      A_IRQ:  reg_rdata = {st_fi, st_fd, st_ur, st_be, 26'd0, ien_q};
      A_TOT:  reg_rdata = tot_q;
      A_DEND: reg_rdata = dend_q;
      A_RTR:  reg_rdata = rtr_q;
      A_HS:   reg_rdata = hs_q;
      A_VS:   reg_rdata = vs_q;
      A_DIV:  reg_rdata = 32'(div_q);
      default: reg_rdata = '0;
    endcase
  end

  AST_IDLE_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (pix_x == 16'd0) && (pix_y == 16'd0));  // R7
  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !h_last) |=> pix_x == 16'($past(pix_x) + 16'd1));  // R1
  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick) |=> $stable(pix_x) && $stable(pix_y));  // R6
  AST_FRAME_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fwrap |=> reg_rdata[30] || (reg_addr != A_IRQ) || st_fd);  // R8
  AST_UR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_wr && reg_wdata[29] && !underrun_evt) |=> !st_ur);  // R10
endmodule

// File: tb/lcd_crtc_gen_test.sv
`timescale 1ns/1ps
module lcd_crtc_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic underrun_evt = 1'b0, bus_err_evt = 1'b0;
  logic hsync_o, vsync_o, de_o, retrace_o, pix_tick_o, irq_o;
  logic [15:0] pix_x, pix_y;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lcd_crtc_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .underrun_evt(underrun_evt), .bus_err_evt(bus_err_evt),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .retrace_o(retrace_o),
    .pix_tick_o(pix_tick_o), .pix_x(pix_x), .pix_y(pix_y), .irq_o(irq_o));

  // n, x, y, hsync, vsync, de, retrace
  localparam int NV = 12;
  localparam int VEC [NV][7] = '{
    '{ 0, 0, 0, 0, 0, 1, 0},
    '{ 5, 5, 0, 0, 0, 1, 0},
    '{ 6, 6, 0, 0, 0, 0, 0},
    '{ 7, 7, 0, 1, 0, 0, 1},
    '{ 8, 8, 0, 1, 0, 0, 1},
    '{ 9, 9, 0, 0, 0, 0, 1},
    '{10, 0, 1, 0, 0, 1, 0},
    '{33, 3, 3, 0, 0, 1, 0},
    '{40, 0, 4, 0, 0, 0, 0},
    '{50, 0, 5, 0, 1, 0, 0},
    '{57, 7, 5, 1, 1, 0, 1},
    '{59, 9, 5, 0, 1, 0, 1}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ur();
    @(negedge clk); underrun_evt = 1'b1;
    @(negedge clk); underrun_evt = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int prev;
    step(3);
    rst_n = 1'b1;
    step(1);
    // reset state: default polarities make syncs idle high, DE idle low
    chk("R7 reset x", 32'(pix_x), 0);
    chk("R7 reset hsync idle", 32'(hsync_o), 1);
    chk("R7 reset vsync idle", 32'(vsync_o), 1);
    chk("R7 reset de idle", 32'(de_o), 0);
    chk("R11 reset irq", 32'(irq_o), 0);
    rd(6'h0C, d); chk("R12 reset total", d, 0);

    wr(6'h0C, 32'h0006_000A);
    wr(6'h10, 32'h0004_0006);
    wr(6'h14, 32'h000B_0007);
    wr(6'h18, 32'hC009_0007);
    wr(6'h1C, 32'h0006_0005);
    wr(6'h04, 32'h0030_0000);
    wr(6'h08, 32'h0000_0001);
    rd(6'h18, d); chk("R3 shift field readback", d, 32'hC009_0007);
    rd(6'h04, d); chk("R12 devctl readback", d, 32'h0030_0000);
    wr(6'h00, 32'h0000_0018);

    prev = 0;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][0] - prev);
      prev = VEC[i][0];
      chk("R1 x", 32'(pix_x), VEC[i][1]);
      chk("R1 y", 32'(pix_y), VEC[i][2]);
      chk("R3 hsync", 32'(hsync_o), VEC[i][3]);
      chk("R4 vsync", 32'(vsync_o), VEC[i][4]);
      chk("R2 de", 32'(de_o), VEC[i][5]);
      chk("R5 retrace", 32'(retrace_o), VEC[i][6]);
    end
    rd(6'h08, d); chk("R8 no early frame status", d, 32'h0000_0001);
    step(1);
    chk("R1 frame wrap x", 32'(pix_x), 0);
    chk("R1 frame wrap y", 32'(pix_y), 0);
    rd(6'h08, d); chk("R8 frame status and int", d, 32'hC000_0001);
    chk("R11 irq on frame", 32'(irq_o), 1);

    wr(6'h08, 32'hC000_0001);
    rd(6'h08, d); chk("R10 frame clear", d, 32'h0000_0001);
    chk("R10 irq after clear", 32'(irq_o), 0);

    wr(6'h00, 32'h0000_0019);
    chk("R7 engine reset hsync idle", 32'(hsync_o), 0);
    chk("R7 engine reset vsync idle", 32'(vsync_o), 0);
    chk("R7 engine reset de idle", 32'(de_o), 0);
    step(1);
    chk("R7 engine reset x", 32'(pix_x), 0);
    chk("R7 engine reset y", 32'(pix_y), 0);

    wr(6'h20, 32'd2);
    wr(6'h00, 32'h0000_0018);
    step(2); chk("R6 div hold", 32'(pix_x), 0);
    step(1); chk("R6 div first tick", 32'(pix_x), 1);
    step(3); chk("R6 div second tick", 32'(pix_x), 2);

    wr(6'h00, 32'h0000_0019);
    wr(6'h20, 32'd0);
    wr(6'h04, 32'h1030_0000);
    wr(6'h00, 32'h0000_0018);
    chk("R2 de active low", 32'(de_o), 0);
    step(6);
    chk("R2 de inactive high", 32'(de_o), 1);

    wr(6'h00, 32'h0000_0010);
    chk("R7 disabled de idle", 32'(de_o), 1);
    chk("R7 disabled hsync idle", 32'(hsync_o), 0);
    step(1);
    chk("R7 disabled x", 32'(pix_x), 0);

    wr(6'h08, 32'h0000_0002);
    pulse_ur();
    rd(6'h08, d); chk("R9 underrun status", d, 32'h2000_0002);
    chk("R11 underrun irq", 32'(irq_o), 1);
    wr(6'h08, 32'h0000_0002);
    rd(6'h08, d); chk("R10 write zero keeps", d, 32'h2000_0002);
    wr(6'h08, 32'h2000_0002);
    rd(6'h08, d); chk("R10 underrun clear", d, 32'h0000_0002);
    chk("R11 irq after clear", 32'(irq_o), 0);

    @(negedge clk); bus_err_evt = 1'b1;
    @(negedge clk); bus_err_evt = 1'b0;
    rd(6'h08, d); chk("R9 bus error status", d, 32'h1000_0002);
    chk("R11 bus error no irq", 32'(irq_o), 0);
    pulse_ur();
    chk("R11 underrun irq again", 32'(irq_o), 1);
    wr(6'h00, 32'h0000_0000);
    chk("R11 global enable off", 32'(irq_o), 0);

    wr(6'h08, 32'hF000_0000);
    rd(6'h08, d); chk("R10 clear all", d, 32'h0000_0000);
    wr(6'h00, 32'h0000_0018);
    step(60);
    rd(6'h08, d); chk("R8 status without int enable", d, 32'h4000_0000);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule